// File: doc/BRIEF.md
# Dual-Clock Reversible Binary Counter

This block is a small binary counter with two separate count inputs: one advances the value, the other steps it back. Both inputs are treated as slow, asynchronous pulse trains. A single system clock samples them through a synchronizer and acts on their rising edges. A counting edge is honoured only while the opposite input rests high. An edge that arrives while the other input is low is dropped and reported on an error output. Two rising edges seen in the same sampled cycle are handled the same way.

A clear input and a parallel-load input act as level-sensitive overrides. They pass through the same synchronizer as the count inputs. Clear wins over load, and load wins over counting.

Two active-low terminal-count outputs support cascading. Each one follows the low phase of its count input while the counter sits at its end value: all ones when counting up, zero when counting down. Each output can therefore be wired straight to the matching count input of the next stage. The next stage then sees exactly one pulse per wrap.

Top module: `updn_pulse_counter`

## Requirements
- R1: A rising edge on `upIn` while `downIn` is high adds one to `count`. The new value appears on the third rising `clk` edge after `upIn` rises: two synchronizer stages, then the count register.
- R2: A rising edge on `downIn` while `upIn` is high subtracts one from `count`, with the same latency as R1.
- R3: The count wraps around. Counting up from all ones (15 at the default width) gives 0, and counting down from 0 gives all ones.
- R4: While `clearIn` is high, `count` is forced to 0. Clear overrides both load and counting.
- R5: While `loadIn` is high and `clearIn` is low, `count` takes the value of `dataIn`. Edges on the count inputs have no effect during this time.
- R6: `carryN` rests high. It is low only while `count` is all ones and the synchronized `upIn` is low. It returns high one clock before the wrapped value appears.
- R7: `borrowN` rests high. It is low only while `count` is 0 and the synchronized `downIn` is low.
- R8: Some edges are rejected, and the count does not change for them:
  - a rising edge on one count input while the other input is low;
  - rising edges on both count inputs in the same sampled cycle.
  Each rejected event drives `seqError` high for exactly one clock, in the cycle where a valid edge would have changed the count.
- R9: Two instances can be chained by wiring the low stage's `carryN` to the high stage's `upIn` and its `borrowN` to the high stage's `downIn`. The pair then counts as one 8-bit value, up and down, across wrap-around.
- R10: While `rstN` is low, `count` is 0, `carryN` and `borrowN` are high, and `seqError` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every other input |
| rstN | input | 1 | Asynchronous active-low reset |
| upIn | input | 1 | Count-up input; a rising edge advances the value |
| downIn | input | 1 | Count-down input; a rising edge steps the value back |
| clearIn | input | 1 | Active-high clear, level-sensitive |
| loadIn | input | 1 | Active-high parallel load, level-sensitive |
| dataIn | input | WIDTH | Value copied into the count during load |
| count | output | WIDTH | Current count |
| carryN | output | 1 | Active-low up terminal count, used as the next stage's up input |
| borrowN | output | 1 | Active-low down terminal count, used as the next stage's down input |
| seqError | output | 1 | One-clock pulse for each rejected count edge |

## Verification
A counting edge can reach the register in the same cycle as a held load or clear. The override must win, and the edge must not be replayed once the override is released. The bench provokes this by holding load, or clear and load together, across complete up and down pulses on a two-stage chain. It then judges the 8-bit value against a reference counter both during the override and after release. Rejected edges are checked the same way: the error pulses are counted, and the count must stay unchanged until a later valid edge moves it by exactly one.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;

  // Strobes from the control to the datapath. At most one is high per cycle.
  typedef struct packed {
    logic clr;
    logic ld;
    logic inc;
    logic dec;
  } ctrlStrobes_t;

endpackage

// File: rtl/updn_sync_bank.sv
module updn_sync_bank #(
  parameter int                 WIDTH     = 1,
  parameter int                 STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  generate
    if (STAGES < 2) begin : gSingle
      logic [WIDTH-1:0] held;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) held <= RESET_VAL;
        else       held <= asyncIn;
      end
      assign syncOut = held;
    end else begin : gChain
      logic [STAGES-1:0][WIDTH-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], asyncIn};
      end
      assign syncOut = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/updn_counter_ctrl.sv
module updn_counter_ctrl
  import updn_counter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         upS,
  input  logic         downS,
  input  logic         clrS,
  input  logic         ldS,
  output ctrlStrobes_t strobes,
  output logic         seqError
);

  logic upPrev;
  logic downPrev;
  logic upRise;
  logic downRise;
  logic badEvent;

  // Both count inputs rest high, so the previous samples reset high
  // and no edge is seen when reset is released.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upPrev   <= 1'b1;
      downPrev <= 1'b1;
    end else begin
      upPrev   <= upS;
      downPrev <= downS;
    end
  end

  assign upRise   = upS & ~upPrev;
  assign downRise = downS & ~downPrev;

  // Rejected: an edge while the other input is low, or two edges at once.
  assign badEvent = (upRise & ~downS) | (downRise & ~upS) | (upRise & downRise);

  always_comb begin
    strobes     = '0;
    strobes.clr = clrS;
    strobes.ld  = ldS & ~clrS;
    strobes.inc = upRise & downS & ~downRise & ~clrS & ~ldS;
    strobes.dec = downRise & upS & ~upRise & ~clrS & ~ldS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqError <= 1'b0;
    else       seqError <= badEvent;
  end

endmodule

// File: rtl/updn_counter_datapath.sv
module updn_counter_datapath
  import updn_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] loadData,
  input  logic             upS,
  input  logic             downS,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);

  localparam logic [WIDTH-1:0] TOP_VAL  = '1;
  localparam logic [WIDTH-1:0] ZERO_VAL = '0;
  localparam logic [WIDTH-1:0] STEP     = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= ZERO_VAL;
    else if (strobes.clr) count <= ZERO_VAL;
    else if (strobes.ld)  count <= loadData;
    else if (strobes.inc) count <= count + STEP;
    else if (strobes.dec) count <= count - STEP;
  end

  // Each terminal count follows the low phase of its count input
  // while the counter sits at that direction's end value.
  assign carryN  = ~((count == TOP_VAL) & ~upS);
  assign borrowN = ~((count == ZERO_VAL) & ~downS);

endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter
  import updn_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upIn,
  input  logic             downIn,
  input  logic             clearIn,
  input  logic             loadIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN,
  output logic             seqError
);

  localparam int               SYNC_W   = WIDTH + 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{WIDTH{1'b0}}, 4'b0011};

  logic [SYNC_W-1:0] syncBus;
  logic [WIDTH-1:0]  dataS;
  logic              clrS;
  logic              ldS;
  logic              upS;
  logic              downS;
  ctrlStrobes_t      strobes;

  updn_sync_bank #(
    .WIDTH     (SYNC_W),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({dataIn, clearIn, loadIn, upIn, downIn}),
    .syncOut (syncBus)
  );

  assign {dataS, clrS, ldS, upS, downS} = syncBus;

  updn_counter_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .upS      (upS),
    .downS    (downS),
    .clrS     (clrS),
    .ldS      (ldS),
    .strobes  (strobes),
    .seqError (seqError)
  );

  updn_counter_datapath #(
    .WIDTH (WIDTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadData (dataS),
    .upS      (upS),
    .downS    (downS),
    .count    (count),
    .carryN   (carryN),
    .borrowN  (borrowN)
  );

endmodule

// File: rtl/updn_pulse_counter_chk.sv
module updn_pulse_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] count,
  input logic             carryN,
  input logic             borrowN,
  input logic             seqError,
  input logic             strbClr,
  input logic             strbLd,
  input logic             strbInc,
  input logic             strbDec,
  input logic [WIDTH-1:0] loadData
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOPV = '1;

  assert_inc_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    strbInc |=> count == WIDTH'($past(count) + ONE));

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strbDec |=> count == WIDTH'($past(count) - ONE));

  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strbInc && count == TOPV) |=> count == '0);

  assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strbDec && count == '0) |=> count == TOPV);

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strbClr |=> count == '0);

  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    strbLd |=> count == $past(loadData));

  assert_single_action_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strbClr, strbLd, strbInc, strbDec}));

  assert_carry_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carryN) |-> $past(count) == TOPV);

  assert_borrow_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(borrowN) |-> $past(count) == '0);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seqError && !$past(strbClr) && !$past(strbLd)) |-> count == $past(count));

endmodule

bind updn_pulse_counter updn_pulse_counter_chk #(
  .WIDTH (WIDTH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .count    (count),
  .carryN   (carryN),
  .borrowN  (borrowN),
  .seqError (seqError),
  .strbClr  (strobes.clr),
  .strbLd   (strobes.ld),
  .strbInc  (strobes.inc),
  .strbDec  (strobes.dec),
  .loadData (dataS)
);

// File: tb/test_updn_pulse_counter.sv
`timescale 1ns/1ps
module test_updn_pulse_counter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upIn = 1'b1;
  logic       downIn = 1'b1;
  logic       clearIn = 1'b0;
  logic       loadIn = 1'b0;
  logic [7:0] dataIn = 8'h00;

  logic [3:0] loCount, hiCount;
  logic       loCarryN, loBorrowN, hiCarryN, hiBorrowN;
  logic       loErr, hiErr;

  always #2.5 clk = ~clk;

  updn_pulse_counter i_updn_pulse_counter (
    .clk(clk), .rstN(rstN), .upIn(upIn), .downIn(downIn),
    .clearIn(clearIn), .loadIn(loadIn), .dataIn(dataIn[3:0]),
    .count(loCount), .carryN(loCarryN), .borrowN(loBorrowN), .seqError(loErr)
  );

  updn_pulse_counter i_hi (
    .clk(clk), .rstN(rstN), .upIn(loCarryN), .downIn(loBorrowN),
    .clearIn(clearIn), .loadIn(loadIn), .dataIn(dataIn[7:4]),
    .count(hiCount), .carryN(hiCarryN), .borrowN(hiBorrowN), .seqError(hiErr)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   sbq[$];
  int         checks = 0;
  int         errors = 0;
  int         loErrPulses = 0;
  int         hiErrPulses = 0;
  logic [7:0] refVal = 8'h00;

  // Monitor: pops expected values and compares against the chained count.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      expItem_t item;
      item = sbq.pop_front();
      checks++;
      if ({hiCount, loCount} !== item.val) begin
        errors++;
        $display("FAIL %s count act=%h exp=%h", item.tag, {hiCount, loCount}, item.val);
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && loErr === 1'b1) loErrPulses++;
    if (rstN && hiErr === 1'b1) hiErrPulses++;
  end

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pushExp(input logic [7:0] v, input string tag);
    expItem_t item;
    item.val = v;
    item.tag = tag;
    sbq.push_back(item);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseUp(input string tag);
    upIn = 1'b0;
    waitCycles(4);
    upIn = 1'b1;
    waitCycles(8);
    refVal = refVal + 8'd1;
    pushExp(refVal, tag);
  endtask

  task automatic pulseDown(input string tag);
    downIn = 1'b0;
    waitCycles(4);
    downIn = 1'b1;
    waitCycles(8);
    refVal = refVal - 8'd1;
    pushExp(refVal, tag);
  endtask

  task automatic doLoad(input logic [7:0] v);
    dataIn = v;
    loadIn = 1'b1;
    waitCycles(4);
    loadIn = 1'b0;
    waitCycles(4);
    refVal = v;
    pushExp(refVal, "R5 load");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    int errBase;

    // R10: reset state
    waitCycles(3);
    checkVal("R10 count", {hiCount, loCount}, 0);
    checkVal("R10 carryN", loCarryN, 1);
    checkVal("R10 borrowN", loBorrowN, 1);
    checkVal("R10 seqError", loErr, 0);
    rstN = 1'b1;
    waitCycles(4);

    // R1: latency of exactly three clock edges
    upIn = 1'b0;
    waitCycles(4);
    upIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 checkVal("R1 before third edge", loCount, 0);
    @(posedge clk);
    #1 checkVal("R1 at third edge", loCount, 1);
    waitCycles(6);
    refVal = 8'h01;
    pushExp(refVal, "R1 first step");

    for (int i = 0; i < 3; i++) pulseUp("R1 up");
    for (int i = 0; i < 2; i++) pulseDown("R2 down");

    // R6 and R9: low stage carries into high stage
    doLoad(8'h0E);
    pulseUp("R1 to 0F");
    upIn = 1'b0;
    waitCycles(4);
    checkVal("R6 carryN low at top", loCarryN, 0);
    checkVal("R6 borrowN rests high", loBorrowN, 1);
    upIn = 1'b1;
    waitCycles(8);
    checkVal("R6 carryN back high", loCarryN, 1);
    refVal = 8'h10;
    pushExp(refVal, "R9 carry chain 0F->10");

    // R7 and R9: borrow into high stage
    downIn = 1'b0;
    waitCycles(4);
    checkVal("R7 borrowN low at zero", loBorrowN, 0);
    checkVal("R7 carryN rests high", loCarryN, 1);
    downIn = 1'b1;
    waitCycles(8);
    checkVal("R7 borrowN back high", loBorrowN, 1);
    refVal = 8'h0F;
    pushExp(refVal, "R9 borrow chain 10->0F");

    // R3: full 8-bit wrap in both directions
    doLoad(8'hFF);
    pulseUp("R3 wrap FF->00");
    pulseDown("R3 wrap 00->FF");
    for (int i = 0; i < 18; i++) pulseUp("R9 up run");
    for (int i = 0; i < 5; i++) pulseDown("R9 down run");

    // R5: held load overrides count pulses
    dataIn = 8'h5A;
    loadIn = 1'b1;
    waitCycles(4);
    upIn = 1'b0;
    waitCycles(4);
    upIn = 1'b1;
    waitCycles(8);
    pushExp(8'h5A, "R5 load overrides up");
    loadIn = 1'b0;
    waitCycles(6);
    refVal = 8'h5A;
    pushExp(refVal, "R5 no replay after load");

    // R4: clear beats load
    dataIn = 8'h33;
    loadIn = 1'b1;
    clearIn = 1'b1;
    waitCycles(6);
    pushExp(8'h00, "R4 clear over load");
    loadIn = 1'b0;
    clearIn = 1'b0;
    waitCycles(6);
    refVal = 8'h00;
    pushExp(refVal, "R4 after release");

    // R4: clear beats counting
    doLoad(8'h40);
    clearIn = 1'b1;
    waitCycles(4);
    downIn = 1'b0;
    waitCycles(4);
    downIn = 1'b1;
    waitCycles(8);
    pushExp(8'h00, "R4 clear over down");
    clearIn = 1'b0;
    waitCycles(6);
    refVal = 8'h00;
    pushExp(refVal, "R4 no replay after clear");

    // R8: edge while the other input is low
    doLoad(8'h25);
    errBase = loErrPulses;
    upIn = 1'b0;
    downIn = 1'b0;
    waitCycles(4);
    upIn = 1'b1;
    waitCycles(6);
    pushExp(8'h25, "R8 rejected up edge");
    waitCycles(1);
    checkVal("R8 one error pulse", loErrPulses - errBase, 1);
    downIn = 1'b1;
    waitCycles(8);
    refVal = 8'h24;
    pushExp(refVal, "R2 later valid down");

    // R8: both edges in the same cycle
    errBase = loErrPulses;
    upIn = 1'b0;
    downIn = 1'b0;
    waitCycles(4);
    upIn = 1'b1;
    downIn = 1'b1;
    waitCycles(8);
    pushExp(8'h24, "R8 simultaneous edges");
    waitCycles(1);
    checkVal("R8 simultaneous error pulse", loErrPulses - errBase, 1);
    checkVal("R8 high stage no error", hiErrPulses, 0);

    waitCycles(4);
    checkVal("R8 queue drained", sbq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule